// File: doc/BRIEF.md
# Calibrated Sensor Code to Temperature Converter

This block turns a raw thermal-sensor ADC code into a signed temperature in millidegrees Celsius. It uses per-device calibration values: an ADC gain error, a slope trim with sign, a calibration temperature, and a room-temperature reference code for each sensor. The result must match a fixed sequence of truncating integer steps bit for bit. It is not a smooth linear fit.

A caller presents the raw code, the calibration fields and a sensor index, then pulses `start_i`. The block registers every operand on that edge. It runs two integer divisions one after the other on a single shared restoring divider. It then forms the scaled product and the final difference, and pulses `done_o` for one cycle. The result stays on `temp_mc_o` until the next conversion completes.

If the calibration data is marked invalid, fixed defaults replace the gain error, the temperature, every sensor reference and the slope trim.

Top module: `thermo_code_conv`

## Requirements
- R1: After reset, `busy_o` is 0, `done_o` is 0 and `temp_mc_o` is 0.
- R2: The result is computed in this order, with every quotient truncated:
  - q1 = 1627604160 / (COEF + slope).
  - q2 = q1 / (10000 + gain).
  - p = (q2 × (raw − ref − 3350)) shifted right arithmetically by 3, so a negative product floors.
  - result = cal_temp × 500 − p.
- R3: The signed slope equals `slope_mag_i` by default. It is negated only when `slope_sign_i` and `dev_id_i` are both 1; either one alone leaves it positive.
- R4: With `cal_valid_i` = 0, the conversion uses these values regardless of what is presented:
  - gain 512;
  - calibration temperature 40;
  - reference 260;
  - slope 0.
- R5: `vts_codes_i` packs one 9-bit reference per sensor, with sensor s at bits [9s+8:9s]. `sensor_sel_i` picks the one used.
- R6: `done_o` rises exactly 66 clock edges after the edge that accepts `start_i`, and it stays high for one cycle only.
- R7: All operands are captured on the accepting edge. Changes to any input during the conversion do not alter the result.
- R8: A `start_i` pulse while `busy_o` is 1 is ignored. It neither restarts the conversion nor produces an extra `done_o`.
- R9: `temp_mc_o` changes only on the edge that raises `done_o`. It holds its value during a conversion and after it, until the next completion.
- R10: `busy_o` is 1 from the accepting edge until the edge that raises `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a conversion (accepted when idle) |
| raw_i | input | RAW_W | Raw sensor ADC code |
| cal_valid_i | input | 1 | Calibration fields are valid |
| gain_err_i | input | 10 | ADC gain error |
| slope_mag_i | input | 6 | Slope trim magnitude |
| slope_sign_i | input | 1 | Slope trim sign flag |
| dev_id_i | input | 1 | Device identity bit, gates the sign flag |
| cal_degc_i | input | 6 | Calibration temperature in degrees |
| vts_codes_i | input | NUM_SENS*9 | Packed per-sensor reference codes |
| sensor_sel_i | input | SEL_W | Sensor whose reference is used |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| temp_mc_o | output | OUT_W | Signed temperature in millidegrees Celsius |

## Verification
The accepting edge is the only time reference, so every output has a fixed due cycle:
- `busy_o` is high at the sample after the accepting edge;
- `done_o` and the new `temp_mc_o` appear 66 edges later;
- nothing else changes in between or afterwards.

The reference model counts edges from acceptance and compares all three outputs at every falling edge against the values due for that count. The same comparison therefore catches an early, late or duplicated pulse and a result that moves outside its edge. The disturbance tests change inputs or re-pulse `start_i` at known counts and keep comparing against values derived from the operands captured at acceptance.

// File: rtl/thermo_conv_pkg.sv
package thermo_conv_pkg;

  localparam int GE_W    = 10;
  localparam int DEGC_W  = 6;
  localparam int VTS_W   = 9;
  localparam int SLOPE_W = 6;
  localparam int NUM_W   = 32;
  localparam int DEN_W   = 16;

  // Numerator constant: 203450520 scaled by 8
  localparam logic [NUM_W-1:0] SCALE_NUM = NUM_W'(32'd203450520 << 3);
  localparam int OFFS_CODE  = 3350;
  localparam int GE_BASE    = 10000;
  localparam int DEGC_MULT  = 500;
  localparam int POST_SHIFT = 3;

  localparam int DEF_GE   = 512;
  localparam int DEF_DEGC = 40;
  localparam int DEF_VTS  = 260;

  typedef struct packed {
    logic [GE_W-1:0]   ge;
    logic [DEGC_W-1:0] degc;
    logic [VTS_W-1:0]  vts;
  } calib_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV1 = 2'd1,
    ST_DIV2 = 2'd2
  } conv_state_t;

endpackage

// File: rtl/calib_select.sv
module calib_select
  import thermo_conv_pkg::*;
#(
  parameter int NUM_SENS = 4,
  parameter int SEL_W    = 2
) (
  input  logic                      cal_valid_i,
  input  logic [GE_W-1:0]           gain_err_i,
  input  logic [SLOPE_W-1:0]        slope_mag_i,
  input  logic                      slope_sign_i,
  input  logic                      dev_id_i,
  input  logic [DEGC_W-1:0]         cal_degc_i,
  input  logic [NUM_SENS*VTS_W-1:0] vts_codes_i,
  input  logic [SEL_W-1:0]          sensor_sel_i,
  output calib_t                    cal_o,
  output logic signed [SLOPE_W:0]   slope_o
);

  logic [VTS_W-1:0] vts_pick;

  // Reference code mux over the packed per-sensor array
  always_comb begin
    vts_pick = '0;
    for (int s = 0; s < NUM_SENS; s++) begin
      if (sensor_sel_i == SEL_W'(s)) vts_pick = vts_codes_i[s*VTS_W +: VTS_W];
    end
  end

  // Substitute defaults when the calibration data is not trustworthy
  always_comb begin
    if (cal_valid_i) begin
      cal_o.ge   = gain_err_i;
      cal_o.degc = cal_degc_i;
      cal_o.vts  = vts_pick;
      if (slope_sign_i && dev_id_i) slope_o = -$signed({1'b0, slope_mag_i});
      else                          slope_o =  $signed({1'b0, slope_mag_i});
    end else begin
      cal_o.ge   = GE_W'(DEF_GE);
      cal_o.degc = DEGC_W'(DEF_DEGC);
      cal_o.vts  = VTS_W'(DEF_VTS);
      slope_o    = '0;
    end
  end

endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int N_W = 32,
  parameter int D_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [N_W-1:0] num_i,
  input  logic [D_W-1:0] den_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [N_W-1:0] quot_o
);

  localparam int CNT_W = $clog2(N_W);

  logic [N_W-1:0]   quo_q, quo_d;
  logic [D_W-1:0]   rem_q, rem_d, den_q, den_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d, done_q, done_d;
  logic [D_W:0]     rem_sh, trial;
  logic             fits, last;

  // One restoring step per cycle: shift in a dividend bit, try subtract
  assign rem_sh = {rem_q, quo_q[N_W-1]};
  assign trial  = rem_sh - {1'b0, den_q};
  assign fits   = ~trial[D_W];
  assign last   = (cnt_q == CNT_W'(N_W-1));

  always_comb begin
    quo_d  = quo_q;
    rem_d  = rem_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (load_i) begin
      quo_d  = num_i;
      rem_d  = '0;
      den_d  = den_i;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      quo_d  = {quo_q[N_W-2:0], fits};
      rem_d  = fits ? trial[D_W-1:0] : rem_sh[D_W-1:0];
      cnt_d  = cnt_q + 1'b1;
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = quo_q;

  // Partial remainder never reaches the divisor (truncating quotient, R2)
  p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q < den_q));

endmodule

// File: rtl/scale_stage.sv
module scale_stage
  import thermo_conv_pkg::*;
#(
  parameter int RAW_W = 12,
  parameter int Q_W   = 32,
  parameter int OUT_W = 32
) (
  input  logic [Q_W-1:0]          quot_i,
  input  logic [RAW_W-1:0]        raw_i,
  input  logic [VTS_W-1:0]        vts_i,
  input  logic [DEGC_W-1:0]       degc_i,
  output logic signed [OUT_W-1:0] temp_o
);

  logic signed [63:0] q_s, delta, prod, shifted, base, res64;

  always_comb begin
    q_s     = 64'(quot_i);
    delta   = 64'(raw_i) - 64'(vts_i) - 64'(OFFS_CODE);
    prod    = q_s * delta;
    shifted = prod >>> POST_SHIFT;
    base    = 64'(degc_i) * 64'(DEGC_MULT);
    res64   = base - shifted;
    temp_o  = res64[OUT_W-1:0];
  end

endmodule

// File: rtl/thermo_code_conv.sv
module thermo_code_conv
  import thermo_conv_pkg::*;
#(
  parameter int NUM_SENS = 4,
  parameter int SEL_W    = 2,
  parameter int RAW_W    = 12,
  parameter int CAL_COEF = 165,
  parameter int OUT_W    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [RAW_W-1:0]          raw_i,
  input  logic                      cal_valid_i,
  input  logic [GE_W-1:0]           gain_err_i,
  input  logic [SLOPE_W-1:0]        slope_mag_i,
  input  logic                      slope_sign_i,
  input  logic                      dev_id_i,
  input  logic [DEGC_W-1:0]         cal_degc_i,
  input  logic [NUM_SENS*VTS_W-1:0] vts_codes_i,
  input  logic [SEL_W-1:0]          sensor_sel_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic signed [OUT_W-1:0]   temp_mc_o
);

  localparam int QW   = NUM_W;
  localparam int DW   = DEN_W;
  localparam int LAT  = 2 * QW + 2;
  localparam int LC_W = $clog2(LAT + 1) + 1;

  calib_t                   cal_live, cal_q;
  logic signed [SLOPE_W:0]  slope_live;
  logic [RAW_W-1:0]         raw_q;
  conv_state_t              st_q, st_d;
  logic                     div_load, div_busy, div_done;
  logic [QW-1:0]            div_num, div_quot;
  logic [DW-1:0]            div_den;
  logic                     cap_en, fin_en, done_q;
  logic signed [OUT_W-1:0]  res_calc, res_q;
  logic [LC_W-1:0]          lat_q;

  calib_select #(.NUM_SENS(NUM_SENS), .SEL_W(SEL_W)) u_cal (
    .cal_valid_i (cal_valid_i),
    .gain_err_i  (gain_err_i),
    .slope_mag_i (slope_mag_i),
    .slope_sign_i(slope_sign_i),
    .dev_id_i    (dev_id_i),
    .cal_degc_i  (cal_degc_i),
    .vts_codes_i (vts_codes_i),
    .sensor_sel_i(sensor_sel_i),
    .cal_o       (cal_live),
    .slope_o     (slope_live)
  );

  seq_divider #(.N_W(QW), .D_W(DW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(div_load),
    .num_i (div_num),
    .den_i (div_den),
    .busy_o(div_busy),
    .done_o(div_done),
    .quot_o(div_quot)
  );

  scale_stage #(.RAW_W(RAW_W), .Q_W(QW), .OUT_W(OUT_W)) u_scale (
    .quot_i(div_quot),
    .raw_i (raw_q),
    .vts_i (cal_q.vts),
    .degc_i(cal_q.degc),
    .temp_o(res_calc)
  );

  assign cap_en = (st_q == ST_IDLE) && start_i;
  assign fin_en = (st_q == ST_DIV2) && div_done;

  // Sequencing: first division uses live slope, second uses captured gain
  always_comb begin
    st_d     = st_q;
    div_load = 1'b0;
    div_num  = SCALE_NUM;
    div_den  = DW'(CAL_COEF) + DW'(slope_live);
    case (st_q)
      ST_IDLE: if (start_i) begin
        div_load = 1'b1;
        st_d     = ST_DIV1;
      end
      ST_DIV1: if (div_done) begin
        div_load = 1'b1;
        div_num  = div_quot;
        div_den  = DW'(GE_BASE) + DW'(cal_q.ge);
        st_d     = ST_DIV2;
      end
      ST_DIV2: if (div_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cal_q  <= '0;
      raw_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
      lat_q  <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= fin_en;
      if (cap_en) begin
        cal_q <= cal_live;
        raw_q <= raw_i;
      end
      if (fin_en) res_q <= res_calc;
      if (cap_en)      lat_q <= '0;
      else if (busy_o) lat_q <= lat_q + 1'b1;
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign temp_mc_o = res_q;

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat_q == LC_W'(LAT)));

  p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(temp_mc_o));

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(raw_q) && $stable(cal_q)));

  p_div_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !div_busy);

endmodule

// File: tb/thermo_code_conv_tb_top.sv
module thermo_code_conv_tb_top;

  localparam int LAT = 66;  // R6: 2*32+2 edges

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [11:0] raw_i;
  logic        cal_valid_i;
  logic [9:0]  gain_err_i;
  logic [5:0]  slope_mag_i;
  logic        slope_sign_i;
  logic        dev_id_i;
  logic [5:0]  cal_degc_i;
  logic [35:0] vts_codes_i;
  logic [1:0]  sensor_sel_i;
  logic        busy_o;
  logic        done_o;
  logic signed [31:0] temp_mc_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int last_exp = 0;

  always #5 clk = ~clk;

  thermo_code_conv dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .raw_i(raw_i),
    .cal_valid_i(cal_valid_i), .gain_err_i(gain_err_i),
    .slope_mag_i(slope_mag_i), .slope_sign_i(slope_sign_i),
    .dev_id_i(dev_id_i), .cal_degc_i(cal_degc_i),
    .vts_codes_i(vts_codes_i), .sensor_sel_i(sensor_sel_i),
    .busy_o(busy_o), .done_o(done_o), .temp_mc_o(temp_mc_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint ref_temp(input int raw, input bit valid, input int ge,
                                      input int mag, input bit sg, input bit id,
                                      input int degc, input int vts);
    longint g, d, v, s, q1, q2, p;
    if (!valid) begin
      g = 512; d = 40; v = 260; s = 0;
    end else begin
      g = ge; d = degc; v = vts;
      s = (sg && id) ? -mag : mag;
    end
    q1 = 64'sd1627604160 / (165 + s);
    q2 = q1 / (10000 + g);
    p  = q2 * (raw - v - 3350);
    p  = p >>> 3;
    return d * 500 - p;
  endfunction

  // One conversion, checked on every falling edge.
  // chg_at: cycle to scramble inputs (R7); rst_at: cycle to re-pulse start (R8)
  task automatic run_case(input string tag, input int raw, input bit valid,
                          input int ge, input int mag, input bit sg, input bit id,
                          input int degc, input int v0, input int v1, input int v2,
                          input int v3, input int sel, input int chg_at,
                          input int rst_at);
    int vts_arr[4];
    int exp_v;
    vts_arr[0] = v0; vts_arr[1] = v1; vts_arr[2] = v2; vts_arr[3] = v3;
    exp_v = int'(ref_temp(raw, valid, ge, mag, sg, id, degc, vts_arr[sel]));
    raw_i = 12'(raw); cal_valid_i = valid; gain_err_i = 10'(ge);
    slope_mag_i = 6'(mag); slope_sign_i = sg; dev_id_i = id;
    cal_degc_i = 6'(degc);
    vts_codes_i = {9'(v3), 9'(v2), 9'(v1), 9'(v0)};
    sensor_sel_i = 2'(sel);
    start_i = 1'b1;
    @(negedge clk);
    for (int i = 0; i <= LAT + 6; i++) begin
      start_i = 1'b0;
      chk({tag, " R10 busy"}, busy_o, (i < LAT) ? 1 : 0);
      chk({tag, " R6 done"},  done_o, (i == LAT) ? 1 : 0);
      chk({tag, " R2/R9 result"}, temp_mc_o, (i >= LAT) ? exp_v : last_exp);
      if (i == chg_at) begin
        raw_i = 12'd4095; cal_valid_i = ~valid; gain_err_i = 10'd3;
        slope_mag_i = 6'd1; slope_sign_i = ~sg; dev_id_i = ~id;
        cal_degc_i = 6'd2; vts_codes_i = '1; sensor_sel_i = 2'(sel + 1);
      end
      if (i == rst_at) begin
        raw_i = 12'd100;
        start_i = 1'b1;
      end
      @(negedge clk);
    end
    last_exp = exp_v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; raw_i = '0; cal_valid_i = 1'b0;
    gain_err_i = '0; slope_mag_i = '0; slope_sign_i = 1'b0; dev_id_i = 1'b0;
    cal_degc_i = '0; vts_codes_i = '0; sensor_sel_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 result", temp_mc_o, 0);

    // R2: nominal, positive delta
    run_case("R2 nominal", 3700, 1, 300, 10, 0, 0, 35, 250, 270, 290, 230, 1, -1, -1);
    // R2: negative product, arithmetic shift floors
    run_case("R2 negative", 3001, 1, 100, 5, 0, 0, 20, 255, 270, 290, 230, 0, -1, -1);
    // R3: sign and id both set -> negated slope
    run_case("R3 negated", 3800, 1, 700, 40, 1, 1, 50, 250, 270, 290, 230, 2, -1, -1);
    // R3: sign alone -> slope stays positive
    run_case("R3 sign only", 3800, 1, 700, 40, 1, 0, 50, 250, 270, 290, 230, 2, -1, -1);
    // R3: id alone -> slope stays positive
    run_case("R3 id only", 3800, 1, 700, 40, 0, 1, 50, 250, 270, 290, 230, 2, -1, -1);
    // R4: invalid calibration uses defaults
    run_case("R4 defaults", 3650, 0, 999, 63, 1, 1, 7, 11, 22, 33, 44, 3, -1, -1);
    // R5: highest sensor index
    run_case("R5 sel3", 3900, 1, 512, 0, 0, 0, 45, 250, 270, 290, 511, 3, -1, -1);
    // R2 extreme: max gain, max negated slope
    run_case("R2 extreme", 4095, 1, 1023, 63, 1, 1, 63, 0, 270, 290, 230, 0, -1, -1);
    // R7: inputs scrambled mid-conversion
    run_case("R7 hold ops", 3555, 1, 222, 17, 0, 1, 33, 240, 261, 280, 300, 1, 10, -1);
    // R8: start pulse while busy is ignored
    run_case("R8 busy start", 3333, 1, 444, 9, 1, 1, 28, 240, 261, 280, 300, 2, -1, 20);
    // R9: back-to-back result hold across a fresh conversion
    run_case("R9 second", 3100, 1, 50, 0, 0, 0, 10, 240, 261, 280, 300, 0, -1, -1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule